// File: doc/BRIEF.md
# Two-Wire Module Management Target

This block is a two-wire serial bus target that answers two device addresses on one shared bus. The first device is a 128-byte identification memory. The second is a bank of 32 sixteen-bit physical-layer control registers, which sit outside the block and are reached through a simple parallel port. Both bus lines are oversampled by the system clock. The block decodes START and STOP conditions, matches the device address, acknowledges or refuses each byte, and keeps a separate auto-incrementing pointer for each device. It drives SDA only through an open-drain pull-low enable.

The identification memory is filled through a byte load port. Two of its bytes hold checksums that are not stored. The block keeps each one as a running sum and updates it whenever a covered byte is loaded. A register access always moves a full 16-bit word as two bytes, high byte first. A write reaches the register port only when the whole word has arrived and been acknowledged.

Top module: `mgmt_twowire_slave`

## Requirements
- R1: While reset is held low, `sda_oe`, `reg_we` and `reg_re` are all 0.
- R2: The block acknowledges a START followed by 7-bit address 0x50 (identification memory) or 0x56 (register bank) plus the read/write bit (1 = read). For any other address it leaves SDA released during the acknowledge clock. The block pulls SDA low only while SCL is low.
- R3: After a write that sets the identification pointer (pointer byte bits [6:0]), each read byte returns the byte at the pointer, and the pointer then advances. It wraps from 127 to 0.
- R4: Byte 63 reads as the low 8 bits of the sum of bytes 0–62. Byte 95 reads as the low 8 bits of the sum of bytes 64–94. Both follow every load. Loads to addresses 63 and 95 do not change what reads back there.
- R5: On the register device, the pointer byte has the form 000yyyyy. A pointer byte with any of bits [7:5] set is not acknowledged.
- R6: A register read gives one `reg_re` pulse, with `reg_addr` equal to the pointer, for each word. The high byte goes on the bus first and the low byte second.
- R7: A register write gives exactly one `reg_we` pulse per word, with `reg_wdata` = {first byte, second byte}. The pulse comes only after the second byte has been acknowledged.
- R8: Register reads and writes both advance the register pointer by one per word, and it wraps from 31 to 0.
- R9: A repeated START after the pointer byte, with no STOP in between, starts a read from the pointer just written.
- R10: A STOP after only the high byte of a register word discards that byte. No write occurs, and the next word starts again with a high byte.
- R11: Data bytes written to the identification device after its pointer byte are not acknowledged, and the memory contents stay unchanged.
- R12: When the bus master refuses a read byte, the block ends the transfer with SDA released and fetches nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| id_we | input | 1 | Load strobe for the identification memory |
| id_waddr | input | 7 | Load address |
| id_wdata | input | 8 | Load data |
| reg_addr | output | 5 | Register index for a read or write strobe |
| reg_wdata | output | 16 | Register write word |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 16 | Register word, valid in the cycle `reg_re` is high |

## Verification
Each kind of internal fault shows up at the ports within one byte time. A pointer that has lost its place returns the wrong byte on the next read clock. It also shows up as a strobe carrying the wrong `reg_addr` in the cycle right after an acknowledge. A half-word flag that is out of step swaps the high and low bytes on the bus, or makes `reg_we` fire after a single byte. The running checksums are read back right after a byte is reloaded, so a stale sum shows up at bytes 63 or 95 in that same transfer.

// File: rtl/mgmt_twowire_slave.sv
module mgmt_twowire_slave #(
  parameter logic [6:0] ID_DEV   = 7'h50,
  parameter logic [6:0] PHY_DEV  = 7'h56,
  parameter int         ID_BYTES = 128,
  parameter int         PHY_REGS = 32,
  parameter int         ID_SUM_A = 63,
  parameter int         ID_SUM_B = 95,
  localparam int        IDW      = $clog2(ID_BYTES),
  localparam int        RW       = $clog2(PHY_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          id_we,
  input  logic [IDW-1:0] id_waddr,
  input  logic [7:0]    id_wdata,
  output logic [RW-1:0] reg_addr,
  output logic [15:0]   reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [15:0]   reg_rdata
);

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_DACK, S_RX, S_RACK, S_TX, S_TACK, S_TNEXT
  } st_t;

  st_t           state;
  logic [2:0]    scl_sy, sda_sy;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, wr_hi, word_lo, byte_in, id_byte;
  logic          sel_phy, is_read, have_ptr, half;
  logic [IDW-1:0] id_ptr, id_nxt;
  logic [RW-1:0] phy_ptr, phy_nxt;
  logic [7:0]    id_mem [ID_BYTES];
  logic [7:0]    sum_a, sum_b;
  logic          sda_s, rise, fall, start_c, stop_c, ptr_ok, rx_ok, fetch_go;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  assign sda_s   = sda_sy[1];
  assign rise    = scl_sy[1] & ~scl_sy[2];
  assign fall    = ~scl_sy[1] & scl_sy[2];
  assign start_c = scl_sy[1] & scl_sy[2] & sda_sy[2] & ~sda_sy[1];
  assign stop_c  = scl_sy[1] & scl_sy[2] & ~sda_sy[2] & sda_sy[1];

  assign byte_in = {shreg[6:0], sda_s};
  assign ptr_ok  = sel_phy ? ((byte_in >> RW) == 8'd0) : 1'b1;
  assign rx_ok   = have_ptr ? sel_phy : ptr_ok;
  assign phy_nxt = (phy_ptr == RW'(PHY_REGS - 1)) ? '0 : phy_ptr + 1'b1;
  assign id_nxt  = (id_ptr == IDW'(ID_BYTES - 1)) ? '0 : id_ptr + 1'b1;

  assign fetch_go = (state == S_DACK && fall && bitcnt == 4'd0 && is_read) ||
                    (state == S_TACK && rise && !sda_s);

  always_comb begin
    if (id_ptr == IDW'(ID_SUM_A))      id_byte = sum_a;
    else if (id_ptr == IDW'(ID_SUM_B)) id_byte = sum_b;
    else                               id_byte = id_mem[id_ptr];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < ID_BYTES; i++) id_mem[i] <= '0;
      sum_a <= '0;
      sum_b <= '0;
    end else if (id_we) begin
      if (id_waddr < IDW'(ID_SUM_A))
        sum_a <= sum_a + id_wdata - id_mem[id_waddr];
      if (id_waddr > IDW'(ID_SUM_A) && id_waddr < IDW'(ID_SUM_B))
        sum_b <= sum_b + id_wdata - id_mem[id_waddr];
      if (id_waddr != IDW'(ID_SUM_A) && id_waddr != IDW'(ID_SUM_B))
        id_mem[id_waddr] <= id_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      sda_oe    <= 1'b0;
      sel_phy   <= 1'b0;
      is_read   <= 1'b0;
      have_ptr  <= 1'b0;
      half      <= 1'b0;
      wr_hi     <= '0;
      word_lo   <= '0;
      id_ptr    <= '0;
      phy_ptr   <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (reg_re) begin
        shreg   <= reg_rdata[15:8];
        word_lo <= reg_rdata[7:0];
      end
      if (start_c) begin
        state    <= S_DEV;
        bitcnt   <= '0;
        sda_oe   <= 1'b0;
        half     <= 1'b0;
        have_ptr <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_DEV: if (rise) begin
            shreg  <= byte_in;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 4'd7) begin
              bitcnt  <= '0;
              is_read <= sda_s;
              if (shreg[6:0] == ID_DEV) begin
                sel_phy <= 1'b0;
                state   <= S_DACK;
              end else if (shreg[6:0] == PHY_DEV) begin
                sel_phy <= 1'b1;
                state   <= S_DACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_DACK: if (fall) begin
            if (bitcnt == 4'd0) begin
              sda_oe <= 1'b1;
              bitcnt <= 4'd1;
            end else begin
              bitcnt <= '0;
              if (is_read) begin
                sda_oe <= ~shreg[7];
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_RX;
              end
            end
          end
          S_RX: if (rise) begin
            shreg  <= byte_in;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              state  <= rx_ok ? S_RACK : S_IDLE;
            end
          end
          S_RACK: if (fall) begin
            if (bitcnt == 4'd0) begin
              sda_oe <= 1'b1;
              bitcnt <= 4'd1;
            end else begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= S_RX;
              if (!have_ptr) begin
                have_ptr <= 1'b1;
                half     <= 1'b0;
                if (sel_phy) phy_ptr <= shreg[RW-1:0];
                else         id_ptr  <= shreg[IDW-1:0];
              end else if (!half) begin
                wr_hi <= shreg;
                half  <= 1'b1;
              end else begin
                reg_we    <= 1'b1;
                reg_addr  <= phy_ptr;
                reg_wdata <= {wr_hi, shreg};
                phy_ptr   <= phy_nxt;
                half      <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (rise) bitcnt <= bitcnt + 1'b1;
            if (fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_TACK;
              end else begin
                sda_oe <= ~shreg[3'(4'd7 - bitcnt)];
              end
            end
          end
          S_TACK: if (rise) state <= sda_s ? S_IDLE : S_TNEXT;
          S_TNEXT: if (fall) begin
            sda_oe <= ~shreg[7];
            bitcnt <= '0;
            state  <= S_TX;
          end
          default: state <= S_IDLE;
        endcase
        if (fetch_go) begin
          if (sel_phy) begin
            if (!half) begin
              reg_re   <= 1'b1;
              reg_addr <= phy_ptr;
              half     <= 1'b1;
            end else begin
              shreg   <= word_lo;
              half    <= 1'b0;
              phy_ptr <= phy_nxt;
            end
          end else begin
            shreg  <= id_byte;
            id_ptr <= id_nxt;
          end
        end
      end
    end

endmodule

module mgmt_twowire_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic reg_we,
  input logic reg_re
);

  assert_we_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_we_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $fell(sda_oe));

  assert_re_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

endmodule

bind mgmt_twowire_slave mgmt_twowire_slave_chk u_chk (.*);

// File: tb/mgmt_twowire_slave_bench.sv
`timescale 1ns/1ps
module mgmt_twowire_slave_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m_low = 1'b0;
  logic        sda_oe, reg_we, reg_re;
  logic        id_we = 1'b0;
  logic [6:0]  id_waddr = '0;
  logic [7:0]  id_wdata = '0;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        sda_line;

  logic [15:0] phy_model [32];
  logic [7:0]  id_model [128];
  logic [20:0] wq [$];
  logic [4:0]  rq [$];
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  bit          ack;
  logic [7:0]  rbuf [8];

  always #2.5 clk = ~clk;

  assign sda_line  = ~(sda_m_low | sda_oe);
  assign reg_rdata = phy_model[reg_addr];

  mgmt_twowire_slave u_mgmt_twowire_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .id_we(id_we), .id_waddr(id_waddr), .id_wdata(id_wdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (wq.size() == 0) check(1'b0, "R7 unexpected write", {11'd0, reg_addr, reg_wdata}, 0);
      else begin
        logic [20:0] e;
        e = wq.pop_front();
        check({reg_addr, reg_wdata} == e, "R7 R8 write port", {11'd0, reg_addr, reg_wdata}, {11'd0, e});
      end
      phy_model[reg_addr] = reg_wdata;
    end
    if (rst_n && reg_re) begin
      if (rq.size() == 0) check(1'b0, "R6 unexpected read strobe", {27'd0, reg_addr}, 0);
      else begin
        logic [4:0] e;
        e = rq.pop_front();
        check(reg_addr == e, "R6 R8 read address", {27'd0, reg_addr}, {27'd0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  function automatic logic [7:0] sum_range(input int lo, input int hi);
    logic [7:0] s = '0;
    for (int i = lo; i <= hi; i++) s = s + id_model[i];
    return s;
  endfunction

  function automatic logic [7:0] exp_id(input int p);
    if (p == 63) return sum_range(0, 62);
    if (p == 95) return sum_range(64, 94);
    return id_model[p];
  endfunction

  task automatic qwait();
    repeat (8) @(negedge clk);
  endtask

  task automatic id_load(input int a, input logic [7:0] d);
    @(negedge clk);
    id_we = 1'b1; id_waddr = 7'(a); id_wdata = d;
    @(negedge clk);
    id_we = 1'b0;
    if (a != 63 && a != 95) id_model[a] = d;
  endtask

  task automatic bstart();
    sda_m_low = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m_low = 1'b1; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bstop();
    sda_m_low = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m_low = 1'b0; qwait();
  endtask

  task automatic wbit(input bit b);
    sda_m_low = !b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic rbit(output bit b);
    sda_m_low = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    b = sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic wbyte(input logic [7:0] v, output bit a);
    bit x;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(x);
    a = !x;
  endtask

  task automatic rbyte(output logic [7:0] v, input bit give_ack);
    bit x;
    for (int i = 7; i >= 0; i--) begin rbit(x); v[i] = x; end
    wbit(!give_ack);
  endtask

  task automatic seq_read(input logic [6:0] dev, input logic [7:0] ptr, input int n);
    bstart();
    wbyte({dev, 1'b0}, ack); check(ack, "R2 address ack", ack, 1);
    wbyte(ptr, ack);         check(ack, "R3 R5 pointer ack", ack, 1);
    bstart();
    wbyte({dev, 1'b1}, ack); check(ack, "R9 read address ack", ack, 1);
    for (int i = 0; i < n; i++) rbyte(rbuf[i], i != n - 1);
    @(negedge clk);
    check(!sda_oe, "R12 released after master nack", sda_oe, 0);
    bstop();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) phy_model[i] = 16'(i * 16'h0101 + 16'h1000);
    phy_model[7] = 16'h0F0F;
    repeat (4) @(negedge clk);
    check(!sda_oe && !reg_we && !reg_re, "R1 reset outputs", {sda_oe, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) id_load(i, 8'((i * 37 + 11) & 255));

    seq_read(7'h50, 8'd60, 4);
    for (int i = 0; i < 4; i++)
      check(rbuf[i] == exp_id(60 + i), "R3 R4 id read bytes 60-63", rbuf[i], exp_id(60 + i));

    id_load(70, 8'hC3);
    id_load(95, 8'h00);
    seq_read(7'h50, 8'd93, 3);
    for (int i = 0; i < 3; i++)
      check(rbuf[i] == exp_id(93 + i), "R4 id checksum after reload", rbuf[i], exp_id(93 + i));

    seq_read(7'h50, 8'd126, 4);
    check(rbuf[0] == exp_id(126) && rbuf[1] == exp_id(127), "R3 id top bytes", {rbuf[0], rbuf[1]}, {exp_id(126), exp_id(127)});
    check(rbuf[2] == exp_id(0) && rbuf[3] == exp_id(1), "R3 id wrap to 0", {rbuf[2], rbuf[3]}, {exp_id(0), exp_id(1)});

    bstart();
    wbyte({7'h51, 1'b0}, ack);
    check(!ack, "R2 foreign address nack", ack, 0);
    bstop();

    bstart();
    wbyte({7'h50, 1'b0}, ack); check(ack, "R2 id address ack", ack, 1);
    wbyte(8'd10, ack);         check(ack, "R3 id pointer ack", ack, 1);
    wbyte(8'h55, ack);         check(!ack, "R11 id data nack", ack, 0);
    bstop();
    seq_read(7'h50, 8'd10, 1);
    check(rbuf[0] == exp_id(10), "R11 id byte unchanged", rbuf[0], exp_id(10));

    wq.push_back({5'd5, 16'hA55A});
    bstart();
    wbyte({7'h56, 1'b0}, ack); check(ack, "R2 phy address ack", ack, 1);
    wbyte(8'd5, ack);          check(ack, "R5 pointer ack", ack, 1);
    wbyte(8'hA5, ack);         check(ack, "R7 high byte ack", ack, 1);
    wbyte(8'h5A, ack);         check(ack, "R7 low byte ack", ack, 1);
    check(wq.size() == 0, "R7 write committed after low ack", wq.size(), 0);
    bstop();

    rq.push_back(5'd5);
    seq_read(7'h56, 8'd5, 2);
    check({rbuf[0], rbuf[1]} == 16'hA55A, "R6 R9 high then low", {rbuf[0], rbuf[1]}, 16'hA55A);

    wq.push_back({5'd31, 16'h1234});
    wq.push_back({5'd0, 16'hBEEF});
    bstart();
    wbyte({7'h56, 1'b0}, ack);
    wbyte(8'd31, ack);
    wbyte(8'h12, ack); wbyte(8'h34, ack);
    wbyte(8'hBE, ack); wbyte(8'hEF, ack);
    check(ack && wq.size() == 0, "R8 write wrap 31 to 0", wq.size(), 0);
    bstop();

    rq.push_back(5'd31);
    rq.push_back(5'd0);
    seq_read(7'h56, 8'd31, 4);
    check({rbuf[0], rbuf[1], rbuf[2], rbuf[3]} == 32'h1234BEEF, "R8 read wrap 31 to 0",
          {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h1234BEEF);
    check(rq.size() == 0, "R6 one strobe per word", rq.size(), 0);

    bstart();
    wbyte({7'h56, 1'b0}, ack);
    wbyte(8'h25, ack);
    check(!ack, "R5 pointer 0x25 nack", ack, 0);
    bstop();
    bstart();
    wbyte({7'h56, 1'b0}, ack);
    wbyte(8'h80, ack);
    check(!ack, "R5 pointer 0x80 nack", ack, 0);
    bstop();

    bstart();
    wbyte({7'h56, 1'b0}, ack);
    wbyte(8'd7, ack);
    wbyte(8'h77, ack);
    bstop();
    rq.push_back(5'd7);
    seq_read(7'h56, 8'd7, 2);
    check({rbuf[0], rbuf[1]} == 16'h0F0F, "R10 partial write discarded", {rbuf[0], rbuf[1]}, 16'h0F0F);

    wq.push_back({5'd7, 16'h1122});
    bstart();
    wbyte({7'h56, 1'b0}, ack);
    wbyte(8'd7, ack);
    wbyte(8'h11, ack);
    wbyte(8'h22, ack);
    bstop();
    check(wq.size() == 0 && phy_model[7] == 16'h1122, "R10 new word starts with high byte", phy_model[7], 16'h1122);

    repeat (10) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule